// File: doc/BRIEF.md
# Power Mode and Clock Divider Controller

This block decides whether the CPU of a small microcontroller runs, sleeps or stands by, and how fast it runs. It has a free-running prescaler. A single-cycle clock enable for the bus master is taken from that prescaler at the system clock divided by 1, 2, 4, 8, 16 or 32. Bus-master state counts are therefore measured in divided-clock states: at divide-by-4, a 4-state memory access spans 16 system cycles. Peripherals that are not bus masters get a separate enable. That enable stays high on every cycle in which the chip is awake, whatever divider is selected.

Software writes a 3-bit clock-select value, a standby enable and a low-speed enable through a plain write strobe. A new clock select waits for the end of a bus cycle before it takes effect. A sleep strobe takes the CPU into sleep or software standby, depending on the configuration. Interrupts bring it back to the same divided clock it had before. A watchdog overflow or the active-low reset pin returns the block to its reset state. The active-low hardware-standby pin stops every clock until the pin is released, and the release goes through the reset state.

All control inputs and outputs are plain level or strobe pins. No stream data passes through the block, so it has no valid/ready handshake.

Top module: `pwr_clk_ctrl`

## Requirements
- R1: While rst_n is low, mode_code is 0 (reset) and both clock enables are low. On the first clock edge after release, mode_code becomes 1 (high speed), the clock select becomes 0, and cpu_clk_en is high on every cycle.
- R2: With an applied select s of 1 to 5, cpu_clk_en is a one-cycle pulse every 2^s system cycles. Any 64 consecutive cycles hold exactly 64/2^s pulses. Select values 6 and 7 behave as 5. mode_code is 2 (medium speed) for any non-zero select.
- R3: A written select value takes effect only at a clock edge where bus_end is high. Until then the previous ratio continues unchanged.
- R4: per_clk_en is high on every cycle in modes 1, 2 and 3, whatever the select.
- R5: sleep_req with stby_en=0 and lowspd_en=0 enters sleep (mode_code 3) at the next edge. In sleep, cpu_clk_en is low and per_clk_en is high.
- R6: In sleep, irq or ext_irq returns the block at the next edge to mode 1 or 2 with the same ratio it had before.
- R7: sleep_req with stby_en=1, lowspd_en=0 and wdt_clksrc=0 enters software standby (mode_code 4), where both enables are low. irq is ignored there. ext_irq returns to the previous ratio.
- R8: sleep_req is ignored (the mode and ratio are unchanged) when lowspd_en=1, or when stby_en=1 and wdt_clksrc=1.
- R9: A wdt_ovf pulse enters mode 0 at the next edge from any mode. The configuration is cleared there. The edge after that gives mode 1. wdt_ovf wins over hw_stby_n.
- R10: With hw_stby_n low (and no wdt_ovf), mode_code is 5 from the next edge, both enables are low and interrupts are ignored. After release there is one cycle in mode 0, then mode 1.
- R11: stby_en and lowspd_en take effect on the edge after the write. Writes are ignored in modes 0 and 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset pin |
| wdt_ovf | input | 1 | Watchdog overflow pulse |
| hw_stby_n | input | 1 | Active-low hardware standby pin |
| wdt_clksrc | input | 1 | Watchdog clock-source bit; must be 0 for software standby |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Clock select to write (0 = undivided, s = divide by 2^s) |
| cfg_stby_en | input | 1 | Standby enable to write |
| cfg_lowspd_en | input | 1 | Low-speed enable to write |
| sleep_req | input | 1 | Sleep instruction strobe |
| bus_end | input | 1 | End of the current bus cycle |
| irq | input | 1 | Any interrupt request |
| ext_irq | input | 1 | External interrupt request |
| cpu_clk_en | output | 1 | Bus-master clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| mode_code | output | 3 | Current mode: 0 reset, 1 high, 2 medium, 3 sleep, 4 software standby, 5 hardware standby |

## Verification
If the applied select is wrong, the gap between cpu_clk_en pulses is wrong, and this shows within one divider period of at most 32 cycles. If the mode state is wrong, mode_code and the two enables show it at the next sampling point after the causing strobe. A lost select value shows after a sleep and wake-up, where the ratio then differs from the one before. A select that is applied too early shows as a change of ratio before bus_end was driven.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
  typedef enum logic [2:0] {
    MODE_RESET  = 3'd0,
    MODE_HIGH   = 3'd1,
    MODE_MEDIUM = 3'd2,
    MODE_SLEEP  = 3'd3,
    MODE_SSTBY  = 3'd4,
    MODE_HSTBY  = 3'd5
  } pwr_mode_e;

  typedef enum logic [2:0] {
    ST_RESET,
    ST_RUN,
    ST_SLEEP,
    ST_SSTBY,
    ST_HSTBY
  } pwr_state_e;

  typedef struct packed {
    logic stby_en;
    logic lowspd_en;
  } pwr_cfg_t;
endpackage

// File: rtl/clk_prescaler.sv
module clk_prescaler #(
  parameter int CNT_W = 5,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int NTAP = CNT_W + 1;
  localparam logic [SEL_W-1:0] MAX_SEL = SEL_W'(CNT_W);

  logic [CNT_W-1:0] cnt;
  logic [NTAP-1:0]  taps;
  logic [SEL_W-1:0] idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + 1'b1;
  end

  assign taps[0] = 1'b1;
  for (genvar k = 1; k < NTAP; k++) begin : g_tap
    assign taps[k] = &cnt[k-1:0];
  end

  always_comb begin
    idx  = (sel > MAX_SEL) ? MAX_SEL : sel;
    tick = taps[idx];
  end
endmodule

// File: rtl/clk_sel_reg.sv
module clk_sel_reg #(
  parameter int SEL_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  pwr_pkg::pwr_cfg_t wr_cfg,
  input  logic              apply,
  output logic [SEL_W-1:0]  act_sel,
  output pwr_pkg::pwr_cfg_t cfg
);
  logic [SEL_W-1:0] pend_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_sel <= '0;
      act_sel  <= '0;
      cfg      <= '0;
    end else if (clear) begin
      pend_sel <= '0;
      act_sel  <= '0;
      cfg      <= '0;
    end else begin
      if (wr_en) begin
        pend_sel <= wr_sel;
        cfg      <= wr_cfg;
      end
      if (apply) act_sel <= pend_sel;
    end
  end
endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wdt_ovf,
  input  logic                hw_stby_n,
  input  logic                wdt_clksrc,
  input  logic                sleep_req,
  input  logic                irq,
  input  logic                ext_irq,
  input  pwr_pkg::pwr_cfg_t   cfg,
  output pwr_pkg::pwr_state_e state
);
  import pwr_pkg::*;

  pwr_state_e nxt;
  logic       go_sleep, go_sstby;

  assign go_sleep = sleep_req && !cfg.stby_en && !cfg.lowspd_en;
  assign go_sstby = sleep_req && cfg.stby_en && !cfg.lowspd_en && !wdt_clksrc;

  always_comb begin
    nxt = state;
    if (wdt_ovf) begin
      nxt = ST_RESET;
    end else if (!hw_stby_n) begin
      nxt = ST_HSTBY;
    end else begin
      unique case (state)
        ST_RESET: nxt = ST_RUN;
        ST_RUN: begin
          if (go_sleep)      nxt = ST_SLEEP;
          else if (go_sstby) nxt = ST_SSTBY;
        end
        ST_SLEEP: if (irq || ext_irq) nxt = ST_RUN;
        ST_SSTBY: if (ext_irq) nxt = ST_RUN;
        ST_HSTBY: nxt = ST_RESET;
        default:  nxt = ST_RESET;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_RESET;
    else        state <= nxt;
  end
endmodule

// File: rtl/pwr_clk_ctrl.sv
module pwr_clk_ctrl #(
  parameter int CNT_W = 5,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wdt_ovf,
  input  logic             hw_stby_n,
  input  logic             wdt_clksrc,
  input  logic             cfg_we,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic             cfg_stby_en,
  input  logic             cfg_lowspd_en,
  input  logic             sleep_req,
  input  logic             bus_end,
  input  logic             irq,
  input  logic             ext_irq,
  output logic             cpu_clk_en,
  output logic             per_clk_en,
  output logic [2:0]       mode_code
);
  import pwr_pkg::*;

  pwr_state_e       state;
  pwr_cfg_t         cfg, wr_cfg;
  logic [SEL_W-1:0] act_sel;
  logic             tick, clear, apply, wr_en;

  assign clear  = (state == ST_RESET) || (state == ST_HSTBY);
  assign apply  = bus_end && (state == ST_RUN);
  assign wr_en  = cfg_we && !clear;
  assign wr_cfg = '{stby_en: cfg_stby_en, lowspd_en: cfg_lowspd_en};

  clk_sel_reg #(.SEL_W(SEL_W)) u_sel (
    .clk(clk), .rst_n(rst_n), .clear(clear), .wr_en(wr_en),
    .wr_sel(cfg_sel), .wr_cfg(wr_cfg), .apply(apply),
    .act_sel(act_sel), .cfg(cfg)
  );

  clk_prescaler #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_div (
    .clk(clk), .rst_n(rst_n), .sel(act_sel), .tick(tick)
  );

  pwr_mode_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .wdt_ovf(wdt_ovf), .hw_stby_n(hw_stby_n),
    .wdt_clksrc(wdt_clksrc), .sleep_req(sleep_req), .irq(irq),
    .ext_irq(ext_irq), .cfg(cfg), .state(state)
  );

  always_comb begin
    cpu_clk_en = (state == ST_RUN) && tick;
    per_clk_en = (state == ST_RUN) || (state == ST_SLEEP);
    unique case (state)
      ST_RUN:   mode_code = (act_sel == '0) ? MODE_HIGH : MODE_MEDIUM;
      ST_SLEEP: mode_code = MODE_SLEEP;
      ST_SSTBY: mode_code = MODE_SSTBY;
      ST_HSTBY: mode_code = MODE_HSTBY;
      default:  mode_code = MODE_RESET;
    endcase
  end
endmodule

// File: rtl/pwr_clk_ctrl_chk.sv
module pwr_clk_ctrl_chk #(
  parameter int SEL_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wdt_ovf,
  input logic             hw_stby_n,
  input logic             bus_end,
  input logic             irq,
  input logic             ext_irq,
  input logic             cpu_clk_en,
  input logic             per_clk_en,
  input logic [2:0]       mode_code,
  input logic [SEL_W-1:0] act_sel
);
  import pwr_pkg::*;

  a_r9_wdt_to_reset: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_ovf |=> mode_code == MODE_RESET);

  a_r10_hstby_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (!wdt_ovf && !hw_stby_n) |=> mode_code == MODE_HSTBY);

  a_r10_hstby_clocks: assert property (@(posedge clk) disable iff (!rst_n)
    mode_code == MODE_HSTBY |-> !cpu_clk_en && !per_clk_en);

  a_r5_sleep_clocks: assert property (@(posedge clk) disable iff (!rst_n)
    mode_code == MODE_SLEEP |-> !cpu_clk_en && per_clk_en);

  a_r7_sstby_clocks: assert property (@(posedge clk) disable iff (!rst_n)
    mode_code == MODE_SSTBY |-> !cpu_clk_en && !per_clk_en);

  a_r4_per_awake: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code == MODE_HIGH || mode_code == MODE_MEDIUM) |-> per_clk_en);

  a_r1_high_every_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    mode_code == MODE_HIGH |-> cpu_clk_en);

  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code == MODE_MEDIUM && cpu_clk_en && !bus_end) |=> !cpu_clk_en);

  a_r3_sel_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_end && mode_code != MODE_RESET && mode_code != MODE_HSTBY)
      |=> $stable(act_sel));

  a_r6_sleep_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code == MODE_SLEEP && (irq || ext_irq) && !wdt_ovf && hw_stby_n)
      |=> (mode_code == MODE_HIGH || mode_code == MODE_MEDIUM));
endmodule

bind pwr_clk_ctrl pwr_clk_ctrl_chk #(.SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wdt_ovf(wdt_ovf), .hw_stby_n(hw_stby_n),
  .bus_end(bus_end), .irq(irq), .ext_irq(ext_irq), .cpu_clk_en(cpu_clk_en),
  .per_clk_en(per_clk_en), .mode_code(mode_code), .act_sel(act_sel)
);

// File: tb/pwr_clk_ctrl_tb.sv
module pwr_clk_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n, wdt_ovf, hw_stby_n, wdt_clksrc, cfg_we;
  logic [2:0] cfg_sel;
  logic cfg_stby_en, cfg_lowspd_en, sleep_req, bus_end, irq, ext_irq;
  logic cpu_clk_en, per_clk_en;
  logic [2:0] mode_code;

  int n_checks = 0;
  int n_errors = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  pwr_clk_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .wdt_ovf(wdt_ovf), .hw_stby_n(hw_stby_n),
    .wdt_clksrc(wdt_clksrc), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_stby_en(cfg_stby_en), .cfg_lowspd_en(cfg_lowspd_en),
    .sleep_req(sleep_req), .bus_end(bus_end), .irq(irq), .ext_irq(ext_irq),
    .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .mode_code(mode_code)
  );

  task automatic check(input int act, input int exp, input string what);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic write_cfg(input logic [2:0] s, input logic sb, input logic ls);
    cfg_we = 1'b1; cfg_sel = s; cfg_stby_en = sb; cfg_lowspd_en = ls;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic pulse_bus_end();
    bus_end = 1'b1; step(); bus_end = 1'b0;
  endtask

  // Count cpu_clk_en pulses over 64 cycles and check the spacing.
  task automatic measure(input int ratio, input string what);
    int cnt = 0, last = -1, gmin = 1000, gmax = 0;
    for (int i = 0; i < 64; i++) begin
      if (cpu_clk_en) begin
        if (last >= 0) begin
          if (i - last < gmin) gmin = i - last;
          if (i - last > gmax) gmax = i - last;
        end
        last = i;
        cnt++;
      end
      step();
    end
    check(cnt, 64 / ratio, {what, " pulse count"});
    check(gmin, ratio, {what, " min gap"});
    check(gmax, ratio, {what, " max gap"});
  endtask

  task automatic sleep_strobe();
    sleep_req = 1'b1; step(); sleep_req = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; step(); step();
    check(mode_code, 0, "R1 mode in reset");
    check(cpu_clk_en, 0, "R1 cpu_clk_en in reset");
    check(per_clk_en, 0, "R1 per_clk_en in reset");
    rst_n = 1'b1; step();
    check(mode_code, 1, "R1 mode after reset");
    measure(1, "R1 undivided");
  endtask

  task automatic t_ratios();
    for (int s = 1; s <= 7; s++) begin
      int r;
      r = (s > 5) ? 32 : (1 << s);
      write_cfg(3'(s), 1'b0, 1'b0);
      pulse_bus_end();
      check(mode_code, 2, $sformatf("R2 mode medium sel=%0d", s));
      measure(r, $sformatf("R2 sel=%0d", s));
      check(per_clk_en, 1, "R4 per_clk_en in medium");
    end
  endtask

  task automatic t_boundary();
    write_cfg(3'd1, 1'b0, 1'b0);
    pulse_bus_end();
    write_cfg(3'd3, 1'b0, 1'b0);
    measure(2, "R3 old ratio kept before bus_end");
    pulse_bus_end();
    measure(8, "R3 new ratio after bus_end");
    write_cfg(3'd0, 1'b0, 1'b0);
    measure(8, "R3 high speed held off");
    pulse_bus_end();
    check(mode_code, 1, "R3 high speed after bus_end");
    measure(1, "R3 undivided after bus_end");
  endtask

  task automatic t_sleep();
    int pulses = 0, per_low = 0;
    write_cfg(3'd3, 1'b0, 1'b0);
    pulse_bus_end();
    sleep_strobe();
    check(mode_code, 3, "R5 sleep entry");
    for (int i = 0; i < 40; i++) begin
      if (cpu_clk_en) pulses++;
      if (!per_clk_en) per_low++;
      step();
    end
    check(pulses, 0, "R5 cpu_clk_en low in sleep");
    check(per_low, 0, "R4 per_clk_en high in sleep");
    irq = 1'b1; step(); irq = 1'b0;
    check(mode_code, 2, "R6 wake from sleep by irq");
    measure(8, "R6 ratio restored after sleep");
    sleep_strobe();
    ext_irq = 1'b1; step(); ext_irq = 1'b0;
    check(mode_code, 2, "R6 wake from sleep by ext_irq");
  endtask

  task automatic t_sstby();
    write_cfg(3'd4, 1'b1, 1'b0);
    pulse_bus_end();
    sleep_strobe();
    check(mode_code, 4, "R7 software standby entry");
    check(per_clk_en, 0, "R7 per_clk_en low in standby");
    check(cpu_clk_en, 0, "R7 cpu_clk_en low in standby");
    irq = 1'b1; step(); irq = 1'b0;
    check(mode_code, 4, "R7 irq ignored in standby");
    ext_irq = 1'b1; step(); ext_irq = 1'b0;
    check(mode_code, 2, "R7 ext_irq wakes standby");
    measure(16, "R7 ratio restored after standby");
  endtask

  task automatic t_ignored();
    write_cfg(3'd2, 1'b0, 1'b1);
    pulse_bus_end();
    sleep_strobe();
    check(mode_code, 2, "R8 sleep ignored with low-speed bit");
    measure(4, "R8 ratio after ignored sleep");
    write_cfg(3'd2, 1'b1, 1'b0);
    wdt_clksrc = 1'b1;
    sleep_strobe();
    check(mode_code, 2, "R8 standby ignored with watchdog source bit");
    wdt_clksrc = 1'b0;
    sleep_strobe();
    check(mode_code, 4, "R11 standby bit effective after write");
    ext_irq = 1'b1; step(); ext_irq = 1'b0;
  endtask

  task automatic t_wdt();
    write_cfg(3'd3, 1'b0, 1'b0);
    pulse_bus_end();
    sleep_strobe();
    wdt_ovf = 1'b1; step(); wdt_ovf = 1'b0;
    check(mode_code, 0, "R9 watchdog reset from sleep");
    check(per_clk_en, 0, "R9 per_clk_en low in reset");
    cfg_we = 1'b1; cfg_sel = 3'd5; step(); cfg_we = 1'b0;
    check(mode_code, 1, "R9 high speed after watchdog reset");
    pulse_bus_end();
    measure(1, "R11 write during reset ignored, select cleared");
    hw_stby_n = 1'b0; wdt_ovf = 1'b1; step(); wdt_ovf = 1'b0; hw_stby_n = 1'b1;
    check(mode_code, 0, "R9 watchdog wins over hardware standby");
    step();
  endtask

  task automatic t_hstby();
    write_cfg(3'd2, 1'b0, 1'b0);
    pulse_bus_end();
    hw_stby_n = 1'b0; step();
    check(mode_code, 5, "R10 hardware standby entry");
    check(cpu_clk_en + per_clk_en, 0, "R10 all enables low");
    irq = 1'b1; ext_irq = 1'b1; step(); irq = 1'b0; ext_irq = 1'b0;
    check(mode_code, 5, "R10 interrupts ignored in hardware standby");
    hw_stby_n = 1'b1; step();
    check(mode_code, 0, "R10 release passes through reset");
    step();
    check(mode_code, 1, "R10 high speed after release");
    measure(1, "R10 select cleared by release");
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        n_errors++;
        $display("FAIL watchdog all requirements actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0; wdt_ovf = 1'b0; hw_stby_n = 1'b1; wdt_clksrc = 1'b0;
    cfg_we = 1'b0; cfg_sel = '0; cfg_stby_en = 1'b0; cfg_lowspd_en = 1'b0;
    sleep_req = 1'b0; bus_end = 1'b0; irq = 1'b0; ext_irq = 1'b0;
    step();
    do_reset();
    t_ratios();
    t_boundary();
    t_sleep();
    t_sstby();
    t_ignored();
    t_wdt();
    t_hstby();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule